// File: doc/BRIEF.md
# Serial Alignment Shifter with Sticky Bit

This block lines up the smaller operand's fraction before a floating-point addition. It shifts the fraction right one bit position per clock cycle. A load strobe captures an unsigned fraction and a shift distance. The unit then counts the distance down to zero and pulses a completion flag. Exponent comparison, the addition, normalization and the rounding decision all happen elsewhere.

Three rounding bits sit below the fraction's least-significant bit. The guard and round bits are the next two positions of the shift chain. The lowest position works differently: it is a sticky flip-flop that ORs in every bit that reaches it and holds a 1 once it has seen one. The rounding logic downstream can therefore tell whether any nonzero bits were lost. Shift distances longer than the chain are handled: the fraction, guard and round bits drain to zero, and every 1 bit of the operand ends up folded into the sticky bit.

Top module: `align_shifter`

## Requirements
- R1: While reset is held, and after it is released, `frac_o`, `guard_o`, `round_o`, `sticky_o`, `busy_o` and `done_o` are all 0. Reset is asserted asynchronously and released on a clock edge.
- R2: A clock edge with `load_i` high captures `frac_i` into the fraction register and the distance `shamt_i` into the counter, and clears guard, round and sticky. With a distance of 0 the captured fraction is presented unchanged with all three rounding bits 0.
- R3: After a load with distance n, the unit performs exactly n single-position shifts, one per cycle. `busy_o` is 1 in exactly those n cycles.
- R4: On each shift, a 0 enters the fraction MSB, the fraction LSB moves into guard, and guard moves into round. The final {frac_o, guard_o, round_o} equals bits [W+2:1] of ({frac_i, 3'b000} >> n), where W is the fraction width.
- R5: The sticky bit's next value is (NOT clear) AND (in OR current), where in is the round bit on a shift cycle and 0 otherwise. After n shifts it equals the OR of every bit at or below position 0 of ({frac_i, 3'b000} >> n).
- R6: `done_o` is a one-cycle pulse. After a load with distance n it is high in the cycle that follows the (n+1)-th rising edge, counting the load edge as the first. A distance of 0 gives done in the cycle right after the load.
- R7: For any distance of W+3 or more, the fraction, guard and round outputs all end at 0, and sticky ends equal to the OR of all bits of `frac_i`.
- R8: Outside a load or a shift, all outputs hold their values, including after done until the next load.
- R9: A load takes priority over a shift in progress, including the final one. The interrupted alignment never raises done, and the result and done timing follow the new load alone.
- R10: The sticky clear dominates. A load clears a sticky bit that is 1, whatever bit is entering it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| load_i | input | 1 | Load strobe for fraction and distance |
| frac_i | input | FRAC_W | Unsigned fraction to align |
| shamt_i | input | CNT_W | Shift distance in bit positions |
| frac_o | output | FRAC_W | Shifted fraction |
| guard_o | output | 1 | First bit below the fraction LSB |
| round_o | output | 1 | Second bit below the fraction LSB |
| sticky_o | output | 1 | OR of everything shifted to or beyond the third position |
| busy_o | output | 1 | High while shifts remain |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A new load can arrive in the same cycle as the final shift of the previous alignment. In that cycle the counter decrement, the done pulse and the sticky accumulation all compete with the load's capture and clear. The bench starts an alignment, counts cycles until exactly one shift remains, and raises a fresh load with a different operand and distance on that cycle. It then requires that no done appears for the abandoned operand. It also requires that the result and done timing match the second operand alone. A separate case reloads while sticky is 1, to show that the clear wins over the bit entering sticky.

// File: rtl/align_pkg.sv
package align_pkg;

  // Rounding bits carried below the fraction LSB, most significant first.
  typedef struct packed {
    logic guard;
    logic round;
    logic sticky;
  } rnd_bits_t;

  localparam int unsigned RND_BITS = 3;

endpackage

// File: rtl/align_rst_sync.sv
module align_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/align_sticky_bit.sv
module align_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic in_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  // Next value: cleared by clr_i, otherwise accumulate the incoming bit.
  always_comb begin
    q_d = ~clr_i & (in_i | q_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_sticky_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !clr_i) |=> q_q);

  assert_sticky_clear_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_q);

  assert_sticky_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !in_i) |=> (q_q == $past(q_q)));

endmodule

// File: rtl/align_count.sv
module align_count #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             done_q;
  logic             done_d;
  logic             active;

  assign active = (cnt_q != '0);

  always_comb begin
    cnt_en = load_i | active;
    if (load_i) cnt_d = amt_i;
    else        cnt_d = cnt_q - ONE;
    if (load_i) done_d = (amt_i == '0);
    else        done_d = (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign shift_o = active & ~load_i;
  assign busy_o  = active;
  assign done_o  = done_q;

  assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_done_at_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));

  assert_load_restarts_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(amt_i)));

endmodule

// File: rtl/align_chain.sv
module align_chain #(
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              guard_o,
  output logic              round_o,
  output logic              sticky_in_o
);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_d;
  logic              guard_q;
  logic              guard_d;
  logic              round_q;
  logic              round_d;
  logic              chain_en;

  // Per-bit next value: load the operand or take the neighbour above.
  for (genvar b = 0; b < FRAC_W; b++) begin : g_bit
    if (b == FRAC_W - 1) begin : g_top
      assign frac_d[b] = load_i ? frac_i[b] : 1'b0;
    end else begin : g_mid
      assign frac_d[b] = load_i ? frac_i[b] : frac_q[b+1];
    end
  end

  always_comb begin
    chain_en = load_i | shift_i;
    guard_d  = load_i ? 1'b0 : frac_q[0];
    round_d  = load_i ? 1'b0 : guard_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= '0;
      guard_q <= 1'b0;
      round_q <= 1'b0;
    end else if (chain_en) begin
      frac_q  <= frac_d;
      guard_q <= guard_d;
      round_q <= round_d;
    end
  end

  assign frac_o      = frac_q;
  assign guard_o     = guard_q;
  assign round_o     = round_q;
  assign sticky_in_o = shift_i & round_q;

  assert_chain_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (guard_q == $past(frac_q[0]) &&
                              round_q == $past(guard_q) &&
                              !frac_q[FRAC_W-1]));

  assert_chain_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> ($stable(frac_q) && $stable(guard_q) && $stable(round_q)));

  assert_chain_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (frac_q == $past(frac_i) && !guard_q && !round_q));

endmodule

// File: rtl/align_shifter.sv
module align_shifter #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [CNT_W-1:0]  shamt_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              guard_o,
  output logic              round_o,
  output logic              sticky_o,
  output logic              busy_o,
  output logic              done_o
);

  import align_pkg::*;

  logic               rst_s_n;
  logic               shift;
  logic               sticky_in;
  logic               sticky_q;
  logic               guard_w;
  logic               round_w;
  rnd_bits_t          rnd;

  align_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  align_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_i  (load_i),
    .amt_i   (shamt_i),
    .shift_o (shift),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  align_chain #(.FRAC_W(FRAC_W)) u_chain (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .load_i      (load_i),
    .shift_i     (shift),
    .frac_i      (frac_i),
    .frac_o      (frac_o),
    .guard_o     (guard_w),
    .round_o     (round_w),
    .sticky_in_o (sticky_in)
  );

  // The load strobe is the sticky flip-flop's clear input.
  align_sticky_bit u_sticky (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr_i (load_i),
    .in_i  (sticky_in),
    .q_o   (sticky_q)
  );

  always_comb begin
    rnd.guard  = guard_w;
    rnd.round  = round_w;
    rnd.sticky = sticky_q;
  end

  assign guard_o  = rnd.guard;
  assign round_o  = rnd.round;
  assign sticky_o = rnd.sticky;

  assert_done_idle_R6 : assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> !busy_o);

  assert_done_pulse_R6 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && !load_i) |=> !done_o);

  assert_reset_state_R1 : assert property (@(posedge clk)
    !rst_s_n |-> (frac_o == '0 && !busy_o && !done_o && !sticky_o));

endmodule

// File: tb/align_shifter_tb.sv
module align_shifter_tb;

  localparam int unsigned FRAC_W     = 16;
  localparam int unsigned CNT_W      = 5;
  localparam int unsigned EXT_W      = FRAC_W + 3;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NVEC       = 12;

  // Stimulus table: {fraction, distance}
  localparam logic [FRAC_W+CNT_W-1:0] VEC [NVEC] = '{
    {16'hA5C3, 5'd0},  {16'h8001, 5'd1},  {16'h0007, 5'd2},  {16'h0007, 5'd3},
    {16'h0004, 5'd3},  {16'h0004, 5'd2},  {16'hFFFF, 5'd8},  {16'h8000, 5'd15},
    {16'h8000, 5'd17}, {16'h8000, 5'd18}, {16'h8000, 5'd19}, {16'h1234, 5'd31}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load_i;
  logic [FRAC_W-1:0] frac_i;
  logic [CNT_W-1:0]  shamt_i;
  logic [FRAC_W-1:0] frac_o;
  logic              guard_o, round_o, sticky_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_shifter #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .frac_i(frac_i), .shamt_i(shamt_i),
    .frac_o(frac_o), .guard_o(guard_o), .round_o(round_o), .sticky_o(sticky_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Reference: wide shift of {f,000}; bits reaching position 0 or below fold into sticky.
  function automatic logic [EXT_W-1:0] model(input logic [FRAC_W-1:0] f, input int n);
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] res;
    ext = {f, 3'b000};
    res = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (ext[i]) begin
        if (i - n >= 1) res[i-n] = 1'b1;
        else            res[0]   = 1'b1;
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [EXT_W-1:0] outs();
    return {frac_o, guard_o, round_o, sticky_o};
  endfunction

  task automatic start(input logic [FRAC_W-1:0] f, input int n);
    load_i  = 1'b1;
    frac_i  = f;
    shamt_i = CNT_W'(n);
    @(negedge clk);
    load_i  = 1'b0;
  endtask

  // Called right after start(): waits for done, checks timing, busy and result.
  task automatic finish_and_check(input logic [FRAC_W-1:0] f, input int n, input string req);
    int k;
    logic busy_ok;
    k = 0;
    busy_ok = 1'b1;
    while (!done_o && k < 64) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk);
      k++;
    end
    check({req, " R6 done latency"}, 64'(k), 64'(n));
    check({req, " R3 busy while shifting"}, 64'(busy_ok), 64'(1));
    check({req, " R4 R5 result"}, 64'(outs()), 64'(model(f, n)));
    check({req, " R6 done idle"}, 64'(busy_o), 64'(0));
    @(negedge clk);
    check({req, " R6 done pulse width"}, 64'(done_o), 64'(0));
    check({req, " R8 hold after done"}, 64'(outs()), 64'(model(f, n)));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [EXT_W-1:0] cap;
    rst_n = 1'b0; load_i = 1'b0; frac_i = '0; shamt_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 64'({outs(), busy_o, done_o}), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 64'({outs(), busy_o, done_o}), 64'(0));

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      start(VEC[v][FRAC_W+CNT_W-1:CNT_W], int'(VEC[v][CNT_W-1:0]));
      finish_and_check(VEC[v][FRAC_W+CNT_W-1:CNT_W], int'(VEC[v][CNT_W-1:0]), "vec");
    end

    // R2: distance 0 presents fraction unchanged, rounding bits clear
    start(16'h5A5A, 0);
    check("R2 zero distance", 64'(outs()), 64'({16'h5A5A, 3'b000}));
    check("R2 zero distance done", 64'(done_o), 64'(1));
    @(negedge clk);

    // R7: far shift, all bits folded into sticky
    start(16'h0100, 25);
    finish_and_check(16'h0100, 25, "R7 far");
    check("R7 far fraction zero", 64'({frac_o, guard_o, round_o}), 64'(0));
    check("R7 far sticky", 64'(sticky_o), 64'(1));

    // R10: sticky is 1 now; a load must clear it
    start(16'hFFFF, 0);
    check("R10 clear wins", 64'(sticky_o), 64'(0));
    @(negedge clk);

    // R9: reload mid-alignment
    start(16'hF00F, 10);
    repeat (3) @(negedge clk);
    start(16'h0FF1, 2);
    finish_and_check(16'h0FF1, 2, "R9 mid");

    // R9: reload on the cycle of the final shift (counter at 1)
    start(16'h00FF, 4);
    repeat (3) @(negedge clk);
    check("R9 final shift pending", 64'(busy_o), 64'(1));
    start(16'hC003, 5);
    finish_and_check(16'hC003, 5, "R9 final");

    // R8: idle outputs stay put over many cycles
    cap = outs();
    repeat (10) @(negedge clk);
    check("R8 long idle", 64'(outs()), 64'(cap));

    // R1: reset in mid-alignment clears everything asynchronously
    start(16'hFFFF, 12);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 64'({outs(), busy_o, done_o}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post reset", 64'({outs(), busy_o, done_o}), 64'(0));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule